// File: doc/BRIEF.md
# IDE Channel Register Front-End

This block turns memory-mapped accesses inside a 4 KiB window into the register operations of one IDE channel. A register index is taken from the access address by dropping its four lowest bits, so registers sit 16 bytes apart. Each register accepts only certain access widths. Accesses to the 16-bit data port, the byte-wide task-file registers and the control/alternate-status register go to a drive-side port. Two registers are held locally: a 32-bit timing word and a 32-bit interrupt state word. The interrupt state word shows the DMA and disk interrupt lines.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read returns its data on a response channel one cycle later. That response stays valid, with stable data, until `rsp_ready` is high on a clock edge. While a response is held back, `req_ready` is low, so back-pressure on responses stalls new requests. Writes produce no response. Data is little-endian and right-aligned on the bus: byte lane 0 is bits 7:0. Access width is given as a byte count in `req_size` (1, 2 or 4).

The drive-side port is combinational. `drv_stb` is high in the cycle a forwarded request is taken, and `drv_rdata` is sampled in that same cycle. The two interrupt inputs are passed straight through to their outputs. They are also folded into the interrupt state word.

Top module: `ide_regfront`

## Requirements
- R1: A read that is taken on one clock edge raises `rsp_valid` after that edge. `rsp_valid` and `rsp_data` then hold until an edge where `rsp_ready` is high. `req_ready` is low exactly while a response is waiting and `rsp_ready` is low.
- R2: Index 0 reads accept sizes 1, 2 and 4 and are forwarded with `drv_sel`=0. A size-1 read is forwarded with `drv_size`=2 and returns `drv_rdata[7:0]` zero-extended. A size-2 read returns `drv_rdata[15:0]`. A size-4 read returns all 32 bits.
- R3: Index 0 writes of size 2 or 4 are forwarded with `drv_we`=1. A size-1 write to index 0 raises no strobe.
- R4: Indices 1 to 7 are forwarded only for size 1, with `drv_sel`=1 and `drv_reg` equal to the index. A read returns `drv_rdata[7:0]`.
- R5: Indices 8 and 0x16 are forwarded only for size 1, with `drv_sel`=2 (alternate status on read, device control on write). A read returns `drv_rdata[7:0]`.
- R6: Index 0x20 is a 32-bit timing word, read and written only with size 4. A read returns the last value written.
- R7: Index 0x30 reads, size 4 only, return the interrupt state word. Bit 31 is the DMA flag, bit 30 is the disk flag, and all other bits are 0.
- R8: The DMA flag is set on a clock edge where the DMA input is high and was low at the previous edge. It is cleared on an edge where the input falls. It is also cleared by a size-4 write to index 0x30 with bit 31 set. A rise on the same edge as such a write leaves the flag set.
- R9: The disk flag takes the disk input's level at each clock edge. Writes to index 0x30 do not affect it.
- R10: `dma_irq_out` equals `dma_irq_in` and `disk_irq_out` equals `disk_irq_in` at all times.
- R11: A read at an unmapped index, or with a size that index does not accept, returns 0xFFFFFFFF and raises no strobe.
- R12: A write at an unmapped index, or with a size that index does not accept, changes no state and raises no strobe. Reset clears the timing word, both flags and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Byte address inside the window |
| req_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| req_wdata | input | DW (32) | Write data, right-aligned |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | DW (32) | Read response data |
| drv_stb | output | 1 | Forwarded access strobe |
| drv_we | output | 1 | Forwarded access is a write |
| drv_sel | output | 2 | 0 data, 1 task file, 2 control/alt status |
| drv_reg | output | 3 | Task-file register number |
| drv_size | output | 3 | Width of the drive access in bytes |
| drv_wdata | output | DW (32) | Data toward the drive |
| drv_rdata | input | DW (32) | Data from the drive, same cycle |
| dma_irq_in | input | 1 | DMA interrupt level |
| disk_irq_in | input | 1 | Disk interrupt level |
| dma_irq_out | output | 1 | DMA interrupt pass-through |
| disk_irq_out | output | 1 | Disk interrupt pass-through |

## Verification
The bench uses the default parameters: a 12-bit address (the full 4 KiB window, so index 0x40 and above can be tried as unmapped), a 32-bit data path with the flags at bits 31 and 30, and two interrupt lines. This reaches every mapped index, both aliases of the control register, and every accepted and rejected width. It also covers the latching DMA flag, including a rise and a clearing write on the same edge. A response held back by `rsp_ready` is exercised as well, to show the stall and the stable data.

// File: rtl/ide_rf_pkg.sv
package ide_rf_pkg;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_DATA   = 3'd1,
    K_TASK   = 3'd2,
    K_CTL    = 3'd3,
    K_TIMING = 3'd4,
    K_IRQ    = 3'd5
  } acc_kind_e;

  localparam int IDX_DATA   = 'h00;
  localparam int IDX_TF_LO  = 'h01;
  localparam int IDX_TF_HI  = 'h07;
  localparam int IDX_CTL_A  = 'h08;
  localparam int IDX_CTL_B  = 'h16;
  localparam int IDX_TIMING = 'h20;
  localparam int IDX_IRQ    = 'h30;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_TASK = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

endpackage

// File: rtl/ide_rf_decode.sv
module ide_rf_decode
  import ide_rf_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic [IW-1:0] idx,
  input  logic [2:0]    size,
  input  logic          write,
  output acc_kind_e     kind
);

  logic sz1, sz2, sz4;
  assign sz1 = (size == 3'd1);
  assign sz2 = (size == 3'd2);
  assign sz4 = (size == 3'd4);

  always_comb begin
    kind = K_NONE;
    if (idx == IW'(IDX_DATA)) begin
      if (write ? (sz2 || sz4) : (sz1 || sz2 || sz4)) kind = K_DATA;
    end else if (idx >= IW'(IDX_TF_LO) && idx <= IW'(IDX_TF_HI)) begin
      if (sz1) kind = K_TASK;
    end else if (idx == IW'(IDX_CTL_A) || idx == IW'(IDX_CTL_B)) begin
      if (sz1) kind = K_CTL;
    end else if (idx == IW'(IDX_TIMING)) begin
      if (sz4) kind = K_TIMING;
    end else if (idx == IW'(IDX_IRQ)) begin
      if (sz4) kind = K_IRQ;
    end
  end

endmodule

// File: rtl/ide_rf_irq.sv
module ide_rf_irq #(
  parameter int            NL     = 2,
  parameter logic [NL-1:0] CLR_EN = NL'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lvl,
  input  logic          clr,
  output logic [NL-1:0] state
);

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic prev;
    if (CLR_EN[g]) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev     <= 1'b0;
          state[g] <= 1'b0;
        end else begin
          prev <= lvl[g];
          if (lvl[g] && !prev)      state[g] <= 1'b1;
          else if (!lvl[g] && prev) state[g] <= 1'b0;
          else if (clr)             state[g] <= 1'b0;
        end
      end
    end else begin : g_follow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev     <= 1'b0;
          state[g] <= 1'b0;
        end else begin
          prev <= lvl[g];
          if (lvl[g] != prev) state[g] <= lvl[g];
        end
      end
    end
  end

endmodule

// File: rtl/ide_rf_resp.sv
module ide_rf_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          in_ready
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ide_regfront.sv
module ide_regfront
  import ide_rf_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int IDX_LSB = 4,
  parameter int NL      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          drv_stb,
  output logic          drv_we,
  output logic [1:0]    drv_sel,
  output logic [2:0]    drv_reg,
  output logic [2:0]    drv_size,
  output logic [DW-1:0] drv_wdata,
  input  logic [DW-1:0] drv_rdata,
  input  logic          dma_irq_in,
  input  logic          disk_irq_in,
  output logic          dma_irq_out,
  output logic          disk_irq_out
);

  localparam int IW = AW - IDX_LSB;

  logic [IW-1:0] idx;
  acc_kind_e     kind;
  logic          fire, rd_fire, wr_fire, fwd;
  logic [DW-1:0] timing_q;
  logic [NL-1:0] irq_state;
  logic [DW-1:0] irq_word;
  logic [DW-1:0] rd_val;
  logic          irq_clr;

  assign idx     = req_addr[AW-1:IDX_LSB];
  assign fire    = req_valid && req_ready;
  assign rd_fire = fire && !req_write;
  assign wr_fire = fire && req_write;

  ide_rf_decode #(.IW(IW)) u_dec (
    .idx   (idx),
    .size  (req_size),
    .write (req_write),
    .kind  (kind)
  );

  // drive-side forwarding
  assign fwd       = (kind == K_DATA) || (kind == K_TASK) || (kind == K_CTL);
  assign drv_stb   = fire && fwd;
  assign drv_we    = req_write;
  assign drv_wdata = req_wdata;
  assign drv_reg   = (kind == K_TASK) ? idx[2:0] : 3'd0;
  assign drv_size  = (kind == K_DATA && !req_write && req_size == 3'd1) ? 3'd2 : req_size;

  always_comb begin
    case (kind)
      K_TASK:  drv_sel = SEL_TASK;
      K_CTL:   drv_sel = SEL_CTL;
      default: drv_sel = SEL_DATA;
    endcase
  end

  // timing word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         timing_q <= '0;
    else if (wr_fire && kind == K_TIMING) timing_q <= req_wdata;
  end

  // interrupt state
  assign irq_clr = wr_fire && (kind == K_IRQ) && req_wdata[DW-1];

  ide_rf_irq #(.NL(NL), .CLR_EN(NL'(1))) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({disk_irq_in, dma_irq_in}),
    .clr   (irq_clr),
    .state (irq_state)
  );

  always_comb begin
    irq_word = '0;
    for (int n = 0; n < NL; n++) irq_word[DW-1-n] = irq_state[n];
  end

  assign dma_irq_out  = dma_irq_in;
  assign disk_irq_out = disk_irq_in;

  // read data selection
  always_comb begin
    rd_val = '1;
    case (kind)
      K_DATA: begin
        if (req_size == 3'd1)      rd_val = DW'(drv_rdata[7:0]);
        else if (req_size == 3'd2) rd_val = DW'(drv_rdata[15:0]);
        else                       rd_val = drv_rdata;
      end
      K_TASK, K_CTL: rd_val = DW'(drv_rdata[7:0]);
      K_TIMING:      rd_val = timing_q;
      K_IRQ:         rd_val = irq_word;
      default:       rd_val = '1;
    endcase
  end

  ide_rf_resp #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_fire),
    .ld_data   (rd_val),
    .out_ready (rsp_ready),
    .out_valid (rsp_valid),
    .out_data  (rsp_data),
    .in_ready  (req_ready)
  );

endmodule

// File: rtl/ide_regfront_chk.sv
module ide_regfront_chk #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int IDX_LSB = 4,
  parameter int NL      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [2:0]    req_size,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          drv_stb,
  input logic          dma_irq_in,
  input logic          disk_irq_in,
  input logic [NL-1:0] irq_state,
  input logic [DW-1:0] timing_q
);

  localparam int IW = AW - IDX_LSB;

  logic [IW-1:0] cidx;
  logic          cfire;
  assign cidx  = req_addr[AW-1:IDX_LSB];
  assign cfire = req_valid && req_ready;

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r3_no_byte_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && req_write && cidx == '0 && req_size == 3'd1 |-> !drv_stb);

  a_r4_taskfile_byte: assert property (@(posedge clk) disable iff (!rst_n)
    drv_stb && cidx >= IW'(1) && cidx <= IW'(7) |-> req_size == 3'd1);

  a_r6_timing_store: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && req_write && cidx == IW'('h20) && req_size == 3'd4
    |=> timing_q == $past(req_wdata));

  a_r8_dma_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_irq_in) |=> irq_state[0]);

  a_r9_disk_track: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(disk_irq_in) |=> irq_state[1] == $past(disk_irq_in));

  a_r11_bad_size_read: assert property (@(posedge clk) disable iff (!rst_n)
    cfire && !req_write && req_size == 3'd3 |=> rsp_valid && rsp_data == '1);

endmodule

bind ide_regfront ide_regfront_chk #(.AW(AW), .DW(DW), .IDX_LSB(IDX_LSB), .NL(NL)) u_chk (.*);

// File: tb/ide_regfront_test.sv
`timescale 1ns/1ps
module ide_regfront_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        drv_stb, drv_we;
  logic [1:0]  drv_sel;
  logic [2:0]  drv_reg, drv_size;
  logic [31:0] drv_wdata;
  logic [31:0] drv_rdata = 32'h9ABC_DE57;
  logic        dma_irq_in = 1'b0, disk_irq_in = 1'b0;
  logic        dma_irq_out, disk_irq_out;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ide_regfront uut (.*);

  // behavioural reference state
  logic        m_prev, m31, m30;
  logic [31:0] m_tim;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev <= 1'b0; m31 <= 1'b0; m30 <= 1'b0; m_tim <= '0;
    end else begin
      m_prev <= dma_irq_in;
      m30    <= disk_irq_in;
      if (dma_irq_in && !m_prev)      m31 <= 1'b1;
      else if (!dma_irq_in && m_prev) m31 <= 1'b0;
      else if (req_valid && req_ready && req_write && req_addr[11:4] == 8'h30 &&
               req_size == 3'd4 && req_wdata[31]) m31 <= 1'b0;
      if (req_valid && req_ready && req_write && req_addr[11:4] == 8'h20 && req_size == 3'd4)
        m_tim <= req_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R10: compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 dma pass", {31'd0, dma_irq_out}, {31'd0, dma_irq_in});
      check("R10 disk pass", {31'd0, disk_irq_out}, {31'd0, disk_irq_in});
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic [2:0] sz);
    logic [7:0] i = a[11:4];
    if (i == 8'h00) begin
      if (sz == 3'd1) return {24'd0, drv_rdata[7:0]};
      if (sz == 3'd2) return {16'd0, drv_rdata[15:0]};
      if (sz == 3'd4) return drv_rdata;
      return 32'hFFFF_FFFF;
    end
    if ((i >= 8'h01 && i <= 8'h07) || i == 8'h08 || i == 8'h16)
      return (sz == 3'd1) ? {24'd0, drv_rdata[7:0]} : 32'hFFFF_FFFF;
    if (i == 8'h20) return (sz == 3'd4) ? m_tim : 32'hFFFF_FFFF;
    if (i == 8'h30) return (sz == 3'd4) ? {m31, m30, 30'd0} : 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  logic [1:0] last_sel;
  logic [2:0] last_reg, last_size;
  logic       last_we;

  task automatic acc(input bit wr, input logic [11:0] a, input logic [2:0] sz,
                     input logic [31:0] wd, input bit exp_stb, input string req);
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    exp = model_read(a, sz);
    #1;
    check({req, " strobe"}, {31'd0, drv_stb}, {31'd0, exp_stb});
    last_sel = drv_sel; last_reg = drv_reg; last_size = drv_size; last_we = drv_we;
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
      check(req, rsp_data, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
    acc(0, 12'h200, 3'd4, 0, 0, "R12 reset timing");
    acc(0, 12'h300, 3'd4, 0, 0, "R12 reset irq word");

    // R6 timing word
    acc(1, 12'h200, 3'd4, 32'hCAFE_1234, 0, "R6 timing write");
    acc(0, 12'h200, 3'd4, 0, 0, "R6 timing readback");
    acc(1, 12'h204, 3'd2, 32'h0000_5555, 0, "R12 timing size2 write");
    acc(0, 12'h200, 3'd4, 0, 0, "R12 timing unchanged");
    acc(0, 12'h200, 3'd1, 0, 0, "R11 timing size1 read");

    // R2 data port reads
    acc(0, 12'h000, 3'd1, 0, 1, "R2 data read b");
    check("R2 drv_size for byte read", {29'd0, last_size}, 32'd2);
    check("R2 drv_sel data", {30'd0, last_sel}, 32'd0);
    acc(0, 12'h000, 3'd2, 0, 1, "R2 data read h");
    drv_rdata = 32'h1357_2468;
    acc(0, 12'h000, 3'd4, 0, 1, "R2 data read w");

    // R3 data port writes
    acc(1, 12'h000, 3'd1, 32'h11, 0, "R3 data byte write");
    acc(1, 12'h000, 3'd2, 32'hBEEF, 1, "R3 data half write");
    check("R3 drv_we", {31'd0, last_we}, 32'd1);
    acc(1, 12'h000, 3'd4, 32'h0102_0304, 1, "R3 data word write");

    // R4 task file
    drv_rdata = 32'hFFFF_FFA7;
    acc(0, 12'h030, 3'd1, 0, 1, "R4 taskfile read");
    check("R4 drv_reg", {29'd0, last_reg}, 32'd3);
    check("R4 drv_sel", {30'd0, last_sel}, 32'd1);
    acc(0, 12'h070, 3'd2, 0, 0, "R4 taskfile half read");
    acc(1, 12'h010, 3'd4, 32'h55, 0, "R4 taskfile word write");
    acc(1, 12'h07F, 3'd1, 32'h55, 1, "R4 taskfile byte write");
    check("R4 drv_reg 7", {29'd0, last_reg}, 32'd7);

    // R5 control / alt status at both indices
    acc(0, 12'h080, 3'd1, 0, 1, "R5 alt status idx8");
    check("R5 drv_sel idx8", {30'd0, last_sel}, 32'd2);
    acc(0, 12'h160, 3'd1, 0, 1, "R5 alt status idx16");
    check("R5 drv_sel idx16", {30'd0, last_sel}, 32'd2);
    acc(1, 12'h160, 3'd1, 32'h02, 1, "R5 control write");
    acc(0, 12'h080, 3'd4, 0, 0, "R11 ctl word read");

    // R11 / R12 unmapped
    acc(0, 12'h090, 3'd1, 0, 0, "R11 unmapped idx9");
    acc(0, 12'h400, 3'd4, 0, 0, "R11 unmapped idx40");
    acc(0, 12'hFF0, 3'd2, 0, 0, "R11 unmapped top");
    acc(0, 12'h000, 3'd3, 0, 0, "R11 size3 data read");
    acc(1, 12'h400, 3'd4, 32'hFFFF_FFFF, 0, "R12 unmapped write");
    acc(0, 12'h200, 3'd4, 0, 0, "R12 timing after stray write");

    // R7 R8 R9 interrupt word
    @(negedge clk); dma_irq_in = 1'b1;
    idle(2);
    acc(0, 12'h300, 3'd4, 0, 0, "R8 dma set");
    @(negedge clk); disk_irq_in = 1'b1;
    idle(2);
    acc(0, 12'h300, 3'd4, 0, 0, "R9 disk set");
    acc(0, 12'h300, 3'd1, 0, 0, "R7 irq byte read");
    acc(1, 12'h300, 3'd4, 32'h7FFF_FFFF, 0, "R8 write no bit31");
    acc(0, 12'h300, 3'd4, 0, 0, "R8 still set");
    acc(1, 12'h300, 3'd4, 32'h8000_0000, 0, "R8 clear write");
    acc(0, 12'h300, 3'd4, 0, 0, "R8 cleared while high");
    check("R8 cleared value", rsp_data, 32'h4000_0000);
    @(negedge clk); dma_irq_in = 1'b0;
    idle(2);
    acc(0, 12'h300, 3'd4, 0, 0, "R8 after fall");
    // rise on the same edge as a clearing write
    @(negedge clk);
    dma_irq_in = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h300; req_size = 3'd4;
    req_wdata = 32'hFFFF_FFFF;
    @(negedge clk); req_valid = 1'b0;
    acc(0, 12'h300, 3'd4, 0, 0, "R8 rise beats clear");
    check("R8 rise beats clear value", rsp_data, 32'hC000_0000);
    @(negedge clk); dma_irq_in = 1'b0; disk_irq_in = 1'b0;
    idle(2);
    acc(0, 12'h300, 3'd4, 0, 0, "R9 both low");

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h200; req_size = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 rsp_valid held", {31'd0, rsp_valid}, 32'd1);
    check("R1 req_ready stalled", {31'd0, req_ready}, 32'd0);
    check("R1 data", rsp_data, 32'hCAFE_1234);
    @(negedge clk);
    check("R1 still valid", {31'd0, rsp_valid}, 32'd1);
    check("R1 data stable", rsp_data, 32'hCAFE_1234);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R1 released", {31'd0, rsp_valid}, 32'd0);
    check("R1 ready again", {31'd0, req_ready}, 32'd1);

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule